// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block runs on the host side of a parallel flash device and works out whether a program or erase operation that software has already launched has finished. After a start pulse it issues status read cycles through a request/acknowledge read port. It watches the toggle bit (bit 6) across consecutive reads and the timeout bit (bit 5) of the newest read, and settles on a verdict of pass or fail.

A toggle seen together with a raised timeout bit is not treated as a failure straight away. Toggling may have stopped in the very cycle the timeout bit rose, so the block takes a fresh pair of reads and only reports failure if that pair still toggles. A failure also raises a one-cycle request for the surrounding logic to write the flash reset command. A read budget set by a parameter bounds the session, so a device that never settles cannot hold the poller forever.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is applied and after it is released, `rd_req_o`, `done_o`, `pass_o`, `fail_o` and `rst_cmd_o` are all 0 until the first start pulse.
- R2: The cycle after `start_i` is sampled high, `rd_req_o` is 1. It stays 1 until the session ends. A read completes on each clock edge where `rd_req_o` and `rd_ack_i` are both 1, and `rd_data_i` is captured on that edge.
- R3: If bit 6 of the second read of a session equals bit 6 of the first read, the session ends with pass.
- R4: If bit 6 differs from the previous read and bit 5 of the newest read is 0, polling goes on. Each further read is compared on bit 6 with the read just before it, and equality gives pass.
- R5: If bit 6 differs from the previous read and bit 5 of the newest read is 1, two more reads are taken. Equal bit 6 in those two gives pass.
- R6: If those two reads still differ on bit 6, the session ends with fail, and `rst_cmd_o` is 1 for exactly the cycle in which `done_o` is 1.
- R7: If the MAX_READS-th read of a session gives no verdict, the session ends with fail and a reset command request. A verdict reached by that same read takes priority over the limit.
- R8: A start pulse during a session aborts it and discards all reads taken so far. Polling begins again from the first pair of reads. A start pulse wins over a read completing in the same cycle.
- R9: `done_o` is a single-cycle pulse in the cycle after the deciding read completes, and `rd_req_o` is 0 in that cycle.
- R10: `pass_o` and `fail_o` are never both 1. They hold their verdict until the next start pulse, and are 0 from the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle pulse that begins (or restarts) a polling session |
| rd_req_o | output | 1 | Read request to the flash bus interface |
| rd_ack_i | input | 1 | Read acknowledge; data is valid on `rd_data_i` in the same cycle |
| rd_data_i | input | DATA_W | Status word returned by the read |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| pass_o | output | 1 | Operation completed successfully (held) |
| fail_o | output | 1 | Operation failed or timed out (held) |
| rst_cmd_o | output | 1 | One-cycle request to write the flash reset command |

## Verification
Every result of this block appears one clock edge after the stimulus that causes it. The read request rises the cycle after a start. The done pulse, the verdict flags and the reset command request appear the cycle after the deciding handshake. The bench drives and samples on the falling edge and steps a behavioural model through the same edge. Each output is therefore compared in the half-cycle where it must already be settled. Acknowledges come in a pseudo-random pattern, so the request-hold rule and the reads that are stretched over several cycles are exercised together with the verdict timing.

// File: rtl/poll_pkg.sv
package poll_pkg;

  // Session phase of the completion poller
  typedef enum logic [2:0] {
    PS_IDLE,     // no session in progress
    PS_FIRST,    // waiting for the first read of a pair
    PS_POLL,     // comparing each new read with the previous one
    PS_RECHK_A,  // first read of the confirmation pair after timeout flag
    PS_RECHK_B   // second read of the confirmation pair
  } poll_state_e;

endpackage

// File: rtl/poll_rst_sync.sv
module poll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/poll_bit_tracker.sv
module poll_bit_tracker #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_IDX  = 6,
  parameter int TIMEOUT_IDX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] data_i,
  output logic              toggled_o,
  output logic              timeout_o
);

  logic prev_tgl_q;
  logic prev_tgl_d;

  always_comb begin
    prev_tgl_d = prev_tgl_q;
    if (cap_en) begin
      prev_tgl_d = data_i[TOGGLE_IDX];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tgl_q <= 1'b0;
    end else begin
      prev_tgl_q <= prev_tgl_d;
    end
  end

  assign toggled_o = data_i[TOGGLE_IDX] ^ prev_tgl_q;
  assign timeout_o = data_i[TIMEOUT_IDX];

endmodule

// File: rtl/poll_read_counter.sv
module poll_read_counter #(
  parameter int MAX_READS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_last_o
);

  localparam int CNT_W = $clog2(MAX_READS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_READS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != LAST)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign at_last_o = (cnt_q == LAST);

  // R7: the count never runs past the read budget
  assert_cnt_in_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import poll_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_IDX  = 6,
  parameter int TIMEOUT_IDX = 5,
  parameter int MAX_READS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              rst_cmd_o
);

  logic        rst_sync_n;
  poll_state_e state_q, state_d;
  logic        done_q, done_d;
  logic        pass_q, pass_d;
  logic        fail_q, fail_d;
  logic        rcmd_q, rcmd_d;
  logic        hs;
  logic        cap_en;
  logic        cnt_clr;
  logic        cnt_inc;
  logic        at_last;
  logic        toggled;
  logic        timeout;
  logic        decided;
  logic        verdict_ok;

  poll_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  poll_bit_tracker #(
    .DATA_W      (DATA_W),
    .TOGGLE_IDX  (TOGGLE_IDX),
    .TIMEOUT_IDX (TIMEOUT_IDX)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_en    (cap_en),
    .data_i    (rd_data_i),
    .toggled_o (toggled),
    .timeout_o (timeout)
  );

  poll_read_counter #(.MAX_READS(MAX_READS)) u_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (cnt_clr),
    .inc_i     (cnt_inc),
    .at_last_o (at_last)
  );

  assign rd_req_o = (state_q != PS_IDLE);
  assign hs       = rd_req_o & rd_ack_i;

  // Next-state and verdict logic
  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    pass_d     = pass_q;
    fail_d     = fail_q;
    rcmd_d     = 1'b0;
    cap_en     = 1'b0;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    decided    = 1'b0;
    verdict_ok = 1'b0;

    if (start_i) begin
      state_d = PS_FIRST;
      pass_d  = 1'b0;
      fail_d  = 1'b0;
      cnt_clr = 1'b1;
    end else if (hs) begin
      cap_en  = 1'b1;
      cnt_inc = 1'b1;
      unique case (state_q)
        PS_FIRST:   state_d = PS_POLL;
        PS_POLL: begin
          if (!toggled) begin
            decided    = 1'b1;
            verdict_ok = 1'b1;
          end else if (timeout) begin
            state_d = PS_RECHK_A;
          end
        end
        PS_RECHK_A: state_d = PS_RECHK_B;
        PS_RECHK_B: begin
          decided    = 1'b1;
          verdict_ok = !toggled;
        end
        default: state_d = PS_IDLE;
      endcase
      if (!decided && at_last) begin
        decided    = 1'b1;
        verdict_ok = 1'b0;
      end
      if (decided) begin
        state_d = PS_IDLE;
        done_d  = 1'b1;
        pass_d  = verdict_ok;
        fail_d  = !verdict_ok;
        rcmd_d  = !verdict_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PS_IDLE;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      rcmd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
      rcmd_q  <= rcmd_d;
    end
  end

  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign rst_cmd_o = rcmd_q;

  // R2: an unacknowledged request is held
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);

  // R2: a start pulse raises the request on the next cycle
  assert_start_req_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> (rd_req_o && !pass_o && !fail_o));

  // R6: reset command request only alongside a failing completion
  assert_rcmd_with_fail_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_cmd_o |-> (done_o && fail_o));

  // R7: a read at the budget limit always closes the session
  assert_limit_closes_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hs && at_last && !start_i) |=> (done_o && !rd_req_o));

  // R9: done is a single-cycle pulse with the request already dropped
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (!rd_req_o && (pass_o ^ fail_o)));

  // R10: verdict flags only move on a start or a completed read
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !hs) |=> ($stable(pass_o) && $stable(fail_o)));

  // R10: never pass and fail together
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(pass_o && fail_o));

endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;

  localparam int DW   = 8;
  localparam int MAXR = 12;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          rd_req_o;
  logic          rd_ack_i;
  logic [DW-1:0] rd_data_i;
  logic          done_o;
  logic          pass_o;
  logic          fail_o;
  logic          rst_cmd_o;

  flash_done_poller #(
    .DATA_W    (DW),
    .MAX_READS (MAXR)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o),
    .rst_cmd_o (rst_cmd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit        m_active = 0;
  int        m_cnt    = 0;
  int        m_phase  = 0;
  bit        m_prev6  = 0;
  bit        m_done   = 0;
  bit        m_pass   = 0;
  bit        m_fail   = 0;
  bit        m_rst    = 0;
  bit        start_next = 0;
  bit        ack_always = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  alt  = 8'h00;
  logic [7:0]  q[$];
  string       cur_tag = "R1";

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] next_data();
    logic [7:0] d;
    if (q.size() > 0) begin
      d = q.pop_front();
    end else begin
      alt = alt ^ 8'h40;
      d = alt;
    end
    return d;
  endfunction

  task automatic step();
    logic       ack;
    logic       hs;
    logic [7:0] d;
    bit         decided;
    bit         ok;
    bit         t6;
    @(negedge clk);
    check("R2", "rd_req_o", rd_req_o, m_active);
    check("R9", "done_o", done_o, m_done);
    check(cur_tag, "pass_o", pass_o, m_pass);
    check(cur_tag, "fail_o", fail_o, m_fail);
    check(cur_tag, "rst_cmd_o", rst_cmd_o, m_rst);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ack = ack_always ? 1'b1 : (lfsr[0] | lfsr[3]);
    hs  = m_active && ack && !start_next;
    d   = hs ? next_data() : 8'h00;
    rd_ack_i  = ack;
    rd_data_i = d;
    start_i   = start_next;
    m_done = 0;
    m_rst  = 0;
    if (start_next) begin
      m_active = 1; m_cnt = 0; m_phase = 0; m_pass = 0; m_fail = 0;
    end else if (hs) begin
      m_cnt++;
      t6 = d[6];
      decided = 0;
      ok = 0;
      if (m_phase == 0) begin
        m_phase = 1;
      end else if (m_phase == 1) begin
        if (t6 == m_prev6) begin decided = 1; ok = 1; end
        else if (d[5]) m_phase = 2;
      end else if (m_phase == 2) begin
        m_phase = 3;
      end else begin
        decided = 1;
        ok = (t6 == m_prev6);
      end
      m_prev6 = t6;
      if (!decided && m_cnt == MAXR) begin decided = 1; ok = 0; end
      if (decided) begin
        m_active = 0; m_done = 1; m_pass = ok; m_fail = !ok; m_rst = !ok;
      end
    end
    start_next = 0;
  endtask

  task automatic run(input string tag, input bit exp_pass);
    int guard;
    cur_tag = tag;
    start_next = 1;
    step();
    guard = 0;
    while (m_active && guard < 400) begin
      step();
      guard++;
    end
    repeat (3) step();
    @(negedge clk);
    check(tag, "final pass_o", pass_o, exp_pass);
    check(tag, "final fail_o", fail_o, !exp_pass);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    rd_ack_i = 1'b0;
    rd_data_i = '0;
    repeat (3) step();
    @(negedge clk);
    // R1: reset state
    check("R1", "reset rd_req_o", rd_req_o, 1'b0);
    check("R1", "reset done_o", done_o, 1'b0);
    check("R1", "reset pass_o", pass_o, 1'b0);
    check("R1", "reset fail_o", fail_o, 1'b0);
    rst_n = 1'b1;
    repeat (6) step();

    // R3: settled at once, bit 5 set but no toggle
    q = '{8'h40, 8'h40};
    run("R3", 1'b1);
    q = '{8'h20, 8'h20};
    run("R3", 1'b1);

    // R4: toggles a few times without timeout, then settles
    q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40};
    run("R4", 1'b1);

    // R5: timeout seen while toggling, confirmation pair settled
    q = '{8'h00, 8'h60, 8'h20, 8'h20};
    run("R5", 1'b1);

    // R6: timeout seen, confirmation pair still toggling
    q = '{8'h40, 8'h20, 8'h60, 8'h20};
    run("R6", 1'b0);

    // R7: device never settles, budget ends the session
    q.delete();
    alt = 8'h00;
    run("R7", 1'b0);

    // R7: verdict on the last budgeted read wins over the limit
    q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
          8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00};
    run("R7", 1'b1);

    // R10: verdict held while idle, cleared by the next start
    repeat (5) step();
    @(negedge clk);
    check("R10", "held pass_o", pass_o, 1'b1);

    // R8: restart in the middle of a session discards earlier reads
    ack_always = 1;
    q = '{8'h00, 8'h40, 8'h40, 8'h40};
    cur_tag = "R8";
    start_next = 1;
    step();
    step();
    step();
    start_next = 1;
    step();
    @(negedge clk);
    check("R10", "cleared pass_o", pass_o, 1'b0);
    check("R8", "restart rd_req_o", rd_req_o, 1'b1);
    while (m_active) step();
    repeat (2) step();
    @(negedge clk);
    check("R8", "restart verdict", pass_o, 1'b1);
    ack_always = 0;

    // R8: restart collides with a completing read
    q = '{8'h00, 8'h40, 8'h40};
    ack_always = 1;
    cur_tag = "R8";
    start_next = 1;
    step();
    step();
    start_next = 1;
    step();
    while (m_active) step();
    ack_always = 0;
    repeat (2) step();

    // R9 with stalls: a failing run after a pass
    q = '{8'h00, 8'h60, 8'h00, 8'h40};
    run("R9", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule